// File: doc/BRIEF.md
# I2C Bit-Clock Prescaler

This block turns a fast reference clock into the timing base of an I2C master. Two programmable counters run in cascade. A small first stage divides by one to four, and a larger second stage divides that result by one to sixty-four. Together they produce a single-cycle sample strobe. The master's input logic uses this strobe to sample the incoming SCL and SDA lines.

A fixed divide-by-22 stage then counts those strobes to set the outgoing SCL bit period. It reports whether the bus clock is in its low half or its high half; each half lasts eleven strobes.

Both divisors come from a 16-bit configuration word that a neighbouring register block decodes, so their bit positions are fixed. When either divisor changes, the whole chain starts again from zero. An enable input holds the chain cleared while it is low.

Top module: `sclk_prescaler`

## Requirements
- R1: While reset is asserted, `sample_stb` and `scl_high` are both 0.
- R2: The first-stage divisor `a` is `cfg_word[15:14]` and the second-stage divisor `b` is `cfg_word[13:8]`. The strobe period is N = (a+1)×(b+1) reference cycles.
- R3: While enabled with unchanged divisors, `sample_stb` is high on exactly one cycle in every N. This covers N=1 (high every cycle) and N=256 (a=3, b=63).
- R4: Let E0 be the first rising edge that samples `en` high after it was low. The first strobe is registered at edge E0+N-1.
- R5: While `en` is low, no strobe is produced, `scl_high` is 0, and every counter, including the SCL phase count, is cleared.
- R6: When a rising edge sees divisor fields that differ from those seen at the previous edge, all counters restart at that edge. The first strobe then follows at edge +N (new N), and the phase count starts again at zero.
- R7: After k strobes since the last restart or enable, `scl_high` is 1 exactly when (k mod 22) ≥ 11. It changes at the same edge as the strobe that causes the change.
- R8: `cfg_word[7:0]` has no effect. Changing it while running neither restarts the counters nor shifts the strobe cadence or the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears all counters |
| cfg_word | input | 16 | Configuration word holding both divisor fields |
| sample_stb | output | 1 | Single-cycle sample strobe, one per N cycles |
| scl_high | output | 1 | 1 during the high half of the SCL period, 0 during the low half |

## Verification
Each result comes from a single register stage. A strobe is due N-1 edges after the first edge that sees `en` high. After a divisor change it is due N edges after the edge that sees the new fields. It then repeats every N edges, and `scl_high` changes on the same edge as its strobe. The driver computes the edge number of every expected strobe from these rules, together with the phase value it must carry, and queues them. Inputs are applied on falling edges, and the monitor samples on falling edges against a rising-edge counter. It pops one entry for each strobe it sees, so an early, late, missing or extra strobe each shows up as a mismatch. At the end of each segment the bench checks that no expected strobe is still left in the queue.

// File: rtl/sclk_prescaler_pkg.sv
package sclk_prescaler_pkg;
  localparam int CFG_W     = 16;
  localparam int FA_W      = 2;
  localparam int FB_W      = 6;
  localparam int FA_LSB    = 14;
  localparam int FB_LSB    = 8;
  localparam int SCL_STEPS = 22;

  typedef struct packed {
    logic [FA_W-1:0] fa;
    logic [FB_W-1:0] fb;
  } div_fields_t;

  function automatic div_fields_t unpack_cfg(input logic [CFG_W-1:0] w);
    div_fields_t f;
    f.fa = w[FA_LSB +: FA_W];
    f.fb = w[FB_LSB +: FB_W];
    return f;
  endfunction
endpackage

// File: rtl/sclk_mod_counter.sv
module sclk_mod_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         at_limit,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;

  assign at_limit = (cnt_q == limit);
  assign wrap     = step && at_limit && !clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)           cnt_d = '0;
    else if (step)     cnt_d = at_limit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen #(
  parameter int STEPS = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic high_half
);
  localparam int PW   = $clog2(STEPS);
  localparam int HALF = STEPS / 2;
  localparam logic [PW-1:0] LAST  = PW'(STEPS - 1);
  localparam logic [PW-1:0] HSTART = PW'(HALF);

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (clr)       ph_d = '0;
    else if (step) ph_d = (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign high_half = (ph_q >= HSTART);
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
  import sclk_prescaler_pkg::*;
#(
  parameter int STEPS = SCL_STEPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             sample_stb,
  output logic             scl_high
);
  div_fields_t fld_now, fld_q;
  logic        restart, clr_all;
  logic        wrap_a, last_a, wrap_b, last_b;
  logic        stb_d, stb_q;
  logic        unused_low;

  assign fld_now    = unpack_cfg(cfg_word);
  assign unused_low = ^cfg_word[FB_LSB-1:0];

  // Divisor snapshot: a mismatch restarts the chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_q <= '0;
    else        fld_q <= fld_now;
  end

  assign restart = (fld_now != fld_q);
  assign clr_all = !en || restart;

  sclk_mod_counter #(.W(FA_W)) u_stage_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_all),
    .step     (1'b1),
    .limit    (fld_now.fa),
    .at_limit (last_a),
    .wrap     (wrap_a)
  );

  sclk_mod_counter #(.W(FB_W)) u_stage_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_all),
    .step     (wrap_a),
    .limit    (fld_now.fb),
    .at_limit (last_b),
    .wrap     (wrap_b)
  );

  assign stb_d = wrap_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  sclk_phase_gen #(.STEPS(STEPS)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_all),
    .step      (stb_d),
    .high_half (scl_high)
  );

  assign sample_stb = stb_q;
endmodule

// File: rtl/sclk_prescaler_chk.sv
module sclk_prescaler_chk
  import sclk_prescaler_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CFG_W-1:0] cfg_word,
  input logic             sample_stb,
  input logic             scl_high
);
  div_fields_t f;
  assign f = unpack_cfg(cfg_word);

  // R1
  always @(posedge clk)
    if (!rst_n) reset_quiet_chk: assert (!sample_stb && !scl_high);

  // R5
  disabled_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sample_stb);

  // R5
  disabled_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_high);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && (f != '0)) |=> !sample_stb);

  // R6
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f != $past(f)) |=> !sample_stb);

  // R7
  phase_rise_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_high) |-> sample_stb);
endmodule

bind sclk_prescaler sclk_prescaler_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .cfg_word   (cfg_word),
  .sample_stb (sample_stb),
  .scl_high   (scl_high)
);

// File: tb/sclk_prescaler_test.sv
module sclk_prescaler_test;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [15:0] cfg_word;
  logic        sample_stb;
  logic        scl_high;

  typedef struct {
    int unsigned due;
    logic        hi;
  } exp_t;

  exp_t        q[$];
  int unsigned cyc;
  int          n_chk, n_fail;
  bit          done;
  bit          mon_on;
  bit          prev_en;
  logic [7:0]  prev_fld;
  int unsigned next_due;
  int unsigned kcnt;

  sclk_prescaler uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cfg_word   (cfg_word),
    .sample_stb (sample_stb),
    .scl_high   (scl_high)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] mk(input int a, input int b, input int low);
    return {2'(a), 6'(b), 8'(low)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected strobe per observed strobe.
  always @(negedge clk) begin
    if (mon_on && rst_n && sample_stb) begin
      if (q.size() == 0) begin
        check(1'b0, "R3", "unexpected strobe at edge", int'(cyc), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == e.due, "R3", "strobe edge", int'(cyc), int'(e.due));
        check(scl_high == e.hi, "R7", "phase at strobe", int'(scl_high), int'(e.hi));
      end
    end
  end

  // Driver: applies a segment and queues its expected strobes.
  task automatic seg(input logic [15:0] w, input bit e_in, input int len);
    int unsigned c0, n;
    logic [7:0] fld;
    c0  = cyc;
    fld = w[15:8];
    n   = (int'(w[15:14]) + 1) * (int'(w[13:8]) + 1);
    cfg_word = w;
    en       = e_in;
    if (!e_in) kcnt = 0;
    else if (!prev_en) begin next_due = c0 + n; kcnt = 0; end      // R4
    else if (fld != prev_fld) begin next_due = c0 + 1 + n; kcnt = 0; end // R6
    if (e_in) begin
      while (next_due <= c0 + len) begin
        exp_t e;
        kcnt++;
        e.due = next_due;
        e.hi  = ((kcnt % 22) >= 11);
        q.push_back(e);
        next_due += n;
      end
    end
    prev_en  = e_in;
    prev_fld = fld;
    repeat (len) @(negedge clk);
    #1;
    check(q.size() == 0, "R3", "expected strobes left over", q.size(), 0);
    if (!e_in) begin
      // R5
      check(!scl_high, "R5", "phase while disabled", int'(scl_high), 0);
      check(!sample_stb, "R5", "strobe while disabled", int'(sample_stb), 0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    cyc = 0; n_chk = 0; n_fail = 0; done = 0; mon_on = 0;
    prev_en = 0; prev_fld = '0; next_due = 0; kcnt = 0;
    rst_n = 1'b0; en = 1'b0; cfg_word = mk(1, 2, 8'h33);
    repeat (3) @(negedge clk);
    // R1
    check(!sample_stb, "R1", "strobe in reset", int'(sample_stb), 0);
    check(!scl_high, "R1", "phase in reset", int'(scl_high), 0);
    cfg_word = '0;
    rst_n = 1'b1;
    mon_on = 1;
    @(negedge clk);
    seg(mk(0, 0, 0), 1'b0, 4);
    seg(mk(1, 2, 8'h5A), 1'b0, 3);        // R2: N=6
    seg(mk(1, 2, 8'h5A), 1'b1, 150);      // R4, R7 wrap
    seg(mk(1, 2, 8'hA5), 1'b1, 40);       // R8
    seg(mk(3, 1, 8'hA5), 1'b1, 100);      // R6: N=8
    seg(mk(3, 1, 8'hA5), 1'b0, 20);       // R5
    seg(mk(0, 0, 8'h01), 1'b0, 3);
    seg(mk(0, 0, 8'h01), 1'b1, 30);       // R3: N=1
    seg(mk(3, 63, 8'h00), 1'b0, 3);
    seg(mk(3, 63, 8'h00), 1'b1, 600);     // R3: N=256
    seg(mk(2, 0, 8'hFF), 1'b1, 50);       // R6: N=3
    seg(mk(2, 0, 8'h0F), 1'b1, 40);       // R8
    done = 1;
    summary();
  end
endmodule